// File: doc/BRIEF.md
# Fault Status and Attention Controller

This block gathers fault and event flags from a light driver's comparators and timers into one 8-bit status word. It drives an attention request for an external open-drain pad: a 1 on `attn_oe` means the pad pulls low. Three thermal and over-temperature flags are sticky. Once set, they stay set until the host reads the status word, and a read is signalled to this block by a one-cycle strobe. The flash-running, flash-ready and flash-overload flags are not sticky. Each shows the state of its source, delayed by one register stage.

The mode controller uses two outputs from this block. `force_ready` tells it to fall back to the safe ready state. `lock_hold` tells it that writes to the flash enable, torch enable and auxiliary LED settings must be refused until the host has read the status word. When the flash timer expires, the block gives a fixed-length attention pulse of `PULSE_CYC` clock cycles. The thermal comparator flags are valid only while the driver is powered (`pwr_on` high). Otherwise they are ignored and their bits are held clear.

Top module: `flag_status_attn`

## Requirements
- R1: After reset, `status` is 0x00 and `attn_oe`, `force_ready` and `lock_hold` are 0. Status bit 7 always reads 0.
- R2: Status bit 6 (flash running), bit 5 (flash ready) and bit 1 (flash overload) each equal the level their source input had at the previous clock edge. None of them is sticky.
- R3: Status bit 4 (warm), bit 3 (hot) and bit 2 (over-temperature) go to 1 one cycle after their source is sampled high. They stay 1 after the source drops, until a status read.
- R4: A status-read strobe clears bits 4, 3 and 2 at the next edge. A source that is still high in the read cycle sets its bit again one cycle later.
- R5: `force_ready` is 1 exactly when status bit 3 or bit 2 is 1.
- R6: Whenever any of status bits 5, 4, 3, 2 or 1 is 1, `attn_oe` is 1. Bits 6 and 0 never assert `attn_oe`.
- R7: A timeout strobe holds `attn_oe` at 1 for exactly `PULSE_CYC` cycles, starting the cycle after the strobe. A new strobe during the pulse restarts the full length.
- R8: Status bit 0 and `lock_hold` are 1 exactly while any of bits 4, 3 or 2 is 1. The next status read releases them.
- R9: While `pwr_on` is 0, `cmp_warm` and `cmp_hot` are ignored, and bits 4 and 3 are 0 from the next cycle on. Bit 2 is not gated by `pwr_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Driver powered; validates the thermal comparators |
| cmp_warm | input | 1 | Thermistor warm-threshold comparator |
| cmp_hot | input | 1 | Thermistor hot-threshold comparator |
| ovt_src | input | 1 | Die over-temperature detector |
| flash_busy | input | 1 | Flash in progress |
| flash_rdy | input | 1 | Flash-ready event level |
| flash_ovr | input | 1 | Flash overload level |
| tmo_stb | input | 1 | One-cycle flash-timer-expired strobe |
| stat_rd | input | 1 | One-cycle strobe: host read the status word |
| status | output | 8 | Status word |
| attn_oe | output | 1 | 1 = pull attention pad low |
| force_ready | output | 1 | Request to enter the safe ready state |
| lock_hold | output | 1 | Refuse writes to the light-enable settings |

## Verification
The bench goes after four corner cases, each of which a faulty design gets wrong in a visible way:

- **Read while the source is still high.** A design that let the set win over the clear would never show the bit dropping. One that dropped the source would lose the event.
- **Timeout strobe in the middle of a pulse.** If the counter extended the pulse or ignored the strobe, the pulse would come out longer or shorter than `PULSE_CYC` after the last strobe.
- **Thermal comparators high with the power flag low.** A design that did not gate them would latch a warning and assert `lock_hold` and `attn_oe`.
- **Flash-running and lock bits set while nothing else is.** Either of them wrongly feeding the attention term would show as `attn_oe` going high.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  localparam int unsigned SW      = 8;
  localparam int unsigned B_RSVD  = 7;
  localparam int unsigned B_BUSY  = 6;
  localparam int unsigned B_RDY   = 5;
  localparam int unsigned B_WARM  = 4;
  localparam int unsigned B_HOT   = 3;
  localparam int unsigned B_OVT   = 2;
  localparam int unsigned B_OVR   = 1;
  localparam int unsigned B_LOCK  = 0;
  localparam int unsigned NLATCH  = 3;
  localparam int unsigned NRT     = 3;

  // sticky flag order inside the latch bank
  typedef enum logic [1:0] {L_WARM = 2'd0, L_HOT = 2'd1, L_OVT = 2'd2} latch_idx_e;

  function automatic logic [SW-1:0] pack_status(input logic [NRT-1:0] rt,
                                                input logic [NLATCH-1:0] lt);
    logic [SW-1:0] s;
    s         = '0;
    s[B_BUSY] = rt[0];
    s[B_RDY]  = rt[1];
    s[B_OVR]  = rt[2];
    s[B_WARM] = lt[L_WARM];
    s[B_HOT]  = lt[L_HOT];
    s[B_OVT]  = lt[L_OVT];
    s[B_LOCK] = |lt;
    return s;
  endfunction
endpackage

// File: rtl/fsa_latch_bank.sv
module fsa_latch_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr || !en_i[i]) q[i] <= 1'b0;
      else if (set_i[i])          q[i] <= 1'b1;
    end

    // R3: a set flag survives while no read and its gate stays open
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr && en_i[i]) |=> q[i]);
    // R4: a read empties the flag at the next edge
    p_clear_on_read_r4: assert property (@(posedge clk) disable iff (rst)
      clr |=> !q[i]);
    // R4: a source held through the read comes back one cycle later
    p_reset_after_read_r4: assert property (@(posedge clk) disable iff (rst)
      (clr && set_i[i] && en_i[i]) |=> ##1 (q[i] || !$past(set_i[i]) || !$past(en_i[i]) || $past(clr)));
    // R9: a closed gate keeps the flag clear
    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
      !en_i[i] |=> !q[i]);
  end
endmodule

// File: rtl/fsa_pulse.sv
module fsa_pulse #(
  parameter int unsigned LEN = 2750
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic active
);
  localparam int unsigned W = $clog2(LEN + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (stb)        cnt <= W'(LEN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R7: strobe starts or restarts the pulse
  p_strobe_starts_r7: assert property (@(posedge clk) disable iff (rst)
    stb |=> active);
  // R7: nothing starts a pulse except a strobe
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    (!active && !stb) |=> !active);
endmodule

// File: rtl/flag_status_attn.sv
module flag_status_attn #(
  parameter int unsigned PULSE_CYC = 2750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_on,
  input  logic       cmp_warm,
  input  logic       cmp_hot,
  input  logic       ovt_src,
  input  logic       flash_busy,
  input  logic       flash_rdy,
  input  logic       flash_ovr,
  input  logic       tmo_stb,
  input  logic       stat_rd,
  output logic [7:0] status,
  output logic       attn_oe,
  output logic       force_ready,
  output logic       lock_hold
);
  import fsa_pkg::*;

  logic [NRT-1:0]    rt_q;
  logic [NLATCH-1:0] lt_q;
  logic [NLATCH-1:0] lt_set;
  logic [NLATCH-1:0] lt_en;
  logic              pulse_on;

  always_ff @(posedge clk) begin
    if (rst) rt_q <= '0;
    else     rt_q <= {flash_ovr, flash_rdy, flash_busy};
  end

  always_comb begin
    lt_set         = '0;
    lt_set[L_WARM] = cmp_warm;
    lt_set[L_HOT]  = cmp_hot;
    lt_set[L_OVT]  = ovt_src;
    lt_en          = '1;
    lt_en[L_WARM]  = pwr_on;
    lt_en[L_HOT]   = pwr_on;
  end

  fsa_latch_bank #(.N(NLATCH)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .clr   (stat_rd),
    .set_i (lt_set),
    .en_i  (lt_en),
    .q     (lt_q)
  );

  fsa_pulse #(.LEN(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .stb    (tmo_stb),
    .active (pulse_on)
  );

  assign status      = pack_status(rt_q, lt_q);
  assign force_ready = lt_q[L_HOT] | lt_q[L_OVT];
  assign lock_hold   = |lt_q;
  assign attn_oe     = rt_q[1] | rt_q[2] | lt_q[L_WARM] | lt_q[L_HOT] | lt_q[L_OVT] | pulse_on;

  // R5: safe-state request only with hot or over-temperature shown
  p_force_src_r5: assert property (@(posedge clk) disable iff (rst)
    force_ready |-> (status[B_HOT] || status[B_OVT]));
  // R6: any attention-class bit pulls the pad
  p_attn_cover_r6: assert property (@(posedge clk) disable iff (rst)
    (|{status[B_RDY], status[B_WARM], status[B_HOT], status[B_OVT], status[B_OVR]}) |-> attn_oe);
  // R8: lock follows the sticky flags
  p_lock_src_r8: assert property (@(posedge clk) disable iff (rst)
    lock_hold |-> (status[B_WARM] || status[B_HOT] || status[B_OVT]));
  // R7: timeout strobe reaches the pad
  p_tmo_attn_r7: assert property (@(posedge clk) disable iff (rst)
    tmo_stb |=> attn_oe);
  // R1: reserved bit is never set
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !status[B_RSVD]);
endmodule

// File: tb/sim_flag_status_attn.sv
module sim_flag_status_attn;
  localparam int unsigned PL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_on = 1'b0, cmp_warm = 1'b0, cmp_hot = 1'b0, ovt_src = 1'b0;
  logic flash_busy = 1'b0, flash_rdy = 1'b0, flash_ovr = 1'b0;
  logic tmo_stb = 1'b0, stat_rd = 1'b0;
  logic [7:0] status;
  logic attn_oe, force_ready, lock_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench reference state
  logic m_busy, m_rdy, m_ovr, m_w, m_h, m_ot;
  int   m_cnt;
  logic prev_rd, prev_pwr;

  always #2 clk = ~clk;

  flag_status_attn #(.PULSE_CYC(PL)) u0 (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .cmp_warm(cmp_warm), .cmp_hot(cmp_hot),
    .ovt_src(ovt_src), .flash_busy(flash_busy), .flash_rdy(flash_rdy),
    .flash_ovr(flash_ovr), .tmo_stb(tmo_stb), .stat_rd(stat_rd),
    .status(status), .attn_oe(attn_oe), .force_ready(force_ready), .lock_hold(lock_hold)
  );

  function automatic logic [7:0] exp_status();
    return {1'b0, m_busy, m_rdy, m_w, m_h, m_ot, m_ovr, (m_w | m_h | m_ot)};
  endfunction

  function automatic logic exp_attn();
    return m_rdy | m_w | m_h | m_ot | m_ovr | (m_cnt != 0);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // reference update for one rising edge, from the requirements
  task automatic model_step();
    prev_rd  = stat_rd;
    prev_pwr = pwr_on;
    if (rst) begin
      m_busy = 0; m_rdy = 0; m_ovr = 0; m_w = 0; m_h = 0; m_ot = 0; m_cnt = 0;
    end else begin
      m_busy = flash_busy; m_rdy = flash_rdy; m_ovr = flash_ovr;      // R2
      m_w  = (stat_rd || !pwr_on) ? 1'b0 : (m_w | cmp_warm);          // R3 R4 R9
      m_h  = (stat_rd || !pwr_on) ? 1'b0 : (m_h | cmp_hot);
      m_ot = stat_rd ? 1'b0 : (m_ot | ovt_src);
      if (tmo_stb) m_cnt = PL;                                       // R7
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
    end
  endtask

  task automatic compare_all();
    logic [7:0] e;
    string lt;
    e = exp_status();
    lt = prev_rd ? "R4" : (!prev_pwr ? "R9" : "R3");
    chk("R1 reserved bit", {7'd0, status[7]}, 8'd0);
    chk("R2 real-time bits", status & 8'h62, e & 8'h62);
    chk({lt, " sticky bits"}, status & 8'h1C, e & 8'h1C);
    chk("R8 lock bit", {6'd0, status[0], lock_hold}, {6'd0, e[0], e[0]});
    chk("R5 force_ready", {7'd0, force_ready}, {7'd0, m_h | m_ot});
    chk((m_cnt != 0) ? "R7 attn pulse" : "R6 attn", {7'd0, attn_oe}, {7'd0, exp_attn()});
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    cmp_warm = 0; cmp_hot = 0; ovt_src = 0; flash_busy = 0; flash_rdy = 0;
    flash_ovr = 0; tmo_stb = 0; stat_rd = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    @(negedge clk);
    cycle(); cycle();
    // R1: reset state
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset outputs", {5'd0, attn_oe, force_ready, lock_hold}, 8'h00);
    rst = 0; pwr_on = 1;
    cycle();

    // R4: read while hot source still high: clear, then set again
    cmp_hot = 1; cycle();
    chk("R3 hot latched", status & 8'h08, 8'h08);
    stat_rd = 1; cycle(); stat_rd = 0;
    chk("R4 cleared by read", status & 8'h1D, 8'h00);
    cycle();
    chk("R4 re-set after read", status & 8'h08, 8'h08);
    cmp_hot = 0; cycle(); cycle();
    chk("R3 held after source drop", status & 8'h08, 8'h08);
    stat_rd = 1; cycle(); stat_rd = 0; cycle();
    chk("R4 released lock", {7'd0, lock_hold}, 8'd0);

    // R9: thermal comparators ignored while unpowered, over-temperature not
    pwr_on = 0; cmp_warm = 1; cmp_hot = 1; ovt_src = 1;
    repeat (3) cycle();
    chk("R9 thermal gated", status & 8'h18, 8'h00);
    chk("R9 overtemp ungated", status & 8'h04, 8'h04);
    quiet(); pwr_on = 1; stat_rd = 1; cycle(); stat_rd = 0; cycle();

    // R6: busy and lock bits alone do not assert attention
    flash_busy = 1; cycle(); cycle();
    chk("R6 busy no attn", {7'd0, attn_oe}, 8'd0);
    quiet(); cycle();

    // R7: pulse length and restart
    tmo_stb = 1; cycle(); tmo_stb = 0;
    repeat (4) cycle();
    tmo_stb = 1; cycle(); tmo_stb = 0;
    for (int k = 1; k < int'(PL); k++) cycle();
    chk("R7 restart still high", {7'd0, attn_oe}, 8'd1);
    cycle();
    chk("R7 pulse ended", {7'd0, attn_oe}, 8'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      pwr_on     = ($urandom % 16) != 0;
      cmp_warm   = ($urandom % 20) == 0;
      cmp_hot    = ($urandom % 30) == 0;
      ovt_src    = ($urandom % 40) == 0;
      flash_busy = ($urandom % 2) == 0;
      flash_rdy  = ($urandom % 6) == 0;
      flash_ovr  = ($urandom % 10) == 0;
      tmo_stb    = ($urandom % 50) == 0;
      stat_rd    = ($urandom % 8) == 0;
      if (($urandom % 200) == 0) rst = 1; else rst = 0;
      cycle();
    end
    quiet(); rst = 0;
    repeat (PL + 2) cycle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule